// File: doc/BRIEF.md
# Partial Reconfiguration Setup Sequencer

This block is a hardware sequencer that takes the place of driver software in the preparation and closing phases of a configuration session run over the host link. It acts as master on a simple 32-bit configuration-register port. It carries out a fixed and strictly ordered list of register reads, read-modify-writes, bursts of dummy data writes and timed status polls. With this list it moves the device into configuration mode before the bitstream is streamed, and it returns the device to user mode afterwards. The bitstream data phase is outside this block.

The host logic pulses `setup_go` or `finish_go` and presents the image flags at the same moment. The sequencer raises `busy` and runs the matching sequence. It then pulses `done` for one cycle and holds a result code on `err_code` until the next accepted command. Setup selects a clocks-per-word ratio from the image flags. Both sequences can stop early with an error code for each cause. Status polls read the status register once per poll interval. The interval is a parameterised count of clock cycles, and the number of reads is the timeout divided by the interval, rounded up.

Top module: `pr_setup_seq`

## Requirements
- R1: A command accepted while `img_partial` is 1 makes no bus transaction. The cycle after acceptance shows `done`=1, `busy`=0 and `err_code`=5.
- R2: Setup first reads the status word at 0x21C. If its enable bit (bit 20) is 0, the sequence stops with `err_code`=1 and makes no further transaction.
- R3: Setup reads mode-control (0x220) and writes it back with bit 1 (clock select) set. It then reads the register again and, in a separate later write, sets bit 0 (configuration mode).
- R4: A dummy burst reads 0x220 and writes it back with bits 15:8 set to 1 and every other bit kept. It then writes the value 0 to the data register 0x228 exactly 244 times. No data write occurs unless the last mode-control write carried a count of 1.
- R5: After the first burst, setup sets bit 0 of program-control (0x22C) by read-modify-write. It then polls status bit 18 until it reads 1, making at most ceil(10/10)=1 read. On failure it ends with `err_code`=2.
- R6: After a successful ready poll, setup runs a second burst and sets bit 1 of 0x22C by read-modify-write. It then rewrites bits 15:8 of 0x220 with 8 if `img_compressed` is 1, else 4 if `img_encrypted` is 1, else 1, and ends with `err_code`=0.
- R7: If bit 18 of the first status read is 1, a full teardown runs before the clock-select step of setup.
- R8: Teardown reads 0x22C and writes it with bit 1 cleared. A second, separate write also clears bit 0. It then runs a dummy burst and polls status bit 18 for 0 with at most 1 read. On failure it ends with `err_code`=2.
- R9: Finish runs teardown and then reads 0x234. If bit 5 is set, it ends with `err_code`=3. Otherwise it writes 0x220 with bits 1:0 cleared and polls until status bits 21 and 24 are both 1, making at most ceil(2000/10)=200 reads. On failure it ends with `err_code`=4.
- R10: After reset `busy`, `done`, `bus_req` and `err_code` are 0. `busy` is 1 from the cycle after acceptance until `done`. `done` lasts one cycle. `bus_req` is never 1 while idle.
- R11: `setup_go` and `finish_go` have no effect while `busy` is 1.
- R12: A transaction holds `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` steady until the cycle in which `bus_ack` is 1. In that cycle read data is taken from `bus_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| setup_go | input | 1 | Start the setup sequence (takes priority over finish) |
| finish_go | input | 1 | Start the finish sequence |
| img_compressed | input | 1 | Image is compressed |
| img_encrypted | input | 1 | Image is encrypted |
| img_partial | input | 1 | Image is a partial reconfiguration image |
| busy | output | 1 | A sequence is running |
| done | output | 1 | One-cycle pulse at the end of a sequence |
| err_code | output | 3 | Result: 0 ok, 1 not enabled, 2 ready timeout, 3 latched error, 4 user-mode timeout, 5 partial rejected |
| bus_req | output | 1 | Register transaction request |
| bus_we | output | 1 | 1 for a write, 0 for a read |
| bus_addr | output | 12 | Register byte offset |
| bus_wdata | output | 32 | Write data |
| bus_ack | input | 1 | Transaction complete |
| bus_rdata | input | 32 | Read data, valid with `bus_ack` |

## Verification
The bench predicts the full transaction trace of every run, including all 244 dummy words. A design that merged the clock-select and mode writes, or cleared both program-control bits in one write, would show a short or reordered trace. The bench presets mode-control with nonzero bits outside the count field, so a burst that failed to preserve them would write wrong data. It starts one setup with the ready bit already set, which exposes a missing teardown. It sets both compressed and encrypted flags, which exposes a wrong ratio priority. Stuck-ready and stuck-user-mode device models check that a timeout ends after exactly 1 or 200 status reads, so an off-by-one retry count shows up. A command pulsed in the middle of a run would leave extra transactions if it were not ignored.

// File: rtl/pr_seq_pkg.sv
package pr_seq_pkg;

    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 12'h21C;
    localparam logic [ADDR_W-1:0] ADDR_MODE   = 12'h220;
    localparam logic [ADDR_W-1:0] ADDR_DATA   = 12'h228;
    localparam logic [ADDR_W-1:0] ADDR_PROG   = 12'h22C;
    localparam logic [ADDR_W-1:0] ADDR_UNCOR  = 12'h234;

    localparam int ST_BIT_READY   = 18;
    localparam int ST_BIT_ENABLE  = 20;
    localparam int ST_BIT_USER    = 21;
    localparam int ST_BIT_FABCLK  = 24;
    localparam int UNCOR_BIT_CFG  = 5;

    localparam logic [DATA_W-1:0] MODE_CFG      = 32'h0000_0001;
    localparam logic [DATA_W-1:0] MODE_CLKSEL   = 32'h0000_0002;
    localparam logic [DATA_W-1:0] MODE_CNT_MASK = 32'h0000_FF00;
    localparam logic [DATA_W-1:0] PROG_REQ      = 32'h0000_0001;
    localparam logic [DATA_W-1:0] PROG_XFER     = 32'h0000_0002;

    typedef enum logic [2:0] {
        ERR_NONE          = 3'd0,
        ERR_NOT_ENABLED   = 3'd1,
        ERR_READY_TIMEOUT = 3'd2,
        ERR_LATCHED       = 3'd3,
        ERR_USER_TIMEOUT  = 3'd4,
        ERR_PARTIAL       = 3'd5
    } err_e;

    typedef enum logic [1:0] {
        POLL_RDY_SET,
        POLL_RDY_CLR,
        POLL_USER
    } poll_e;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_CHECK,
        ST_CLKSEL_RD,
        ST_CLKSEL_WR,
        ST_MODE_RD,
        ST_MODE_WR,
        ST_REQ_RD,
        ST_REQ_WR,
        ST_XFER_RD,
        ST_XFER_WR,
        ST_RATIO_RD,
        ST_RATIO_WR,
        ST_TD_PROG_RD,
        ST_TD_XFER_CLR,
        ST_TD_CFG_CLR,
        ST_FIN_ERR_RD,
        ST_FIN_MODE_RD,
        ST_FIN_MODE_WR,
        ST_BURST_RD,
        ST_BURST_WR,
        ST_BURST_DATA,
        ST_POLL_RD,
        ST_POLL_WAIT
    } state_e;

    typedef struct packed {
        state_e              state;
        state_e              ret;
        state_e              td_ret;
        poll_e               poll;
        logic [DATA_W-1:0]   data;
        logic [7:0]          ratio;
        err_e                err;
        logic                done;
    } seq_t;

endpackage

// File: rtl/pr_seq_countdown.sv
module pr_seq_countdown #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         is_zero
);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (dec && cnt_q != '0) begin
            cnt_d = cnt_q - W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count   = cnt_q;
    assign is_zero = (cnt_q == '0);

endmodule

// File: rtl/pr_seq_ratio.sv
module pr_seq_ratio #(
    parameter int RATIO_COMP  = 8,
    parameter int RATIO_ENC   = 4,
    parameter int RATIO_PLAIN = 1
) (
    input  logic       compressed,
    input  logic       encrypted,
    output logic [7:0] ratio
);

    always_comb begin
        if (compressed) begin
            ratio = 8'(RATIO_COMP);
        end else if (encrypted) begin
            ratio = 8'(RATIO_ENC);
        end else begin
            ratio = 8'(RATIO_PLAIN);
        end
    end

endmodule

// File: rtl/pr_setup_seq.sv
module pr_setup_seq
    import pr_seq_pkg::*;
#(
    parameter int CLK_PER_US   = 100,
    parameter int POLL_US      = 10,
    parameter int READY_TMO_US = 10,
    parameter int USER_TMO_US  = 2000,
    parameter int DUMMY_WORDS  = 244
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        setup_go,
    input  logic        finish_go,
    input  logic        img_compressed,
    input  logic        img_encrypted,
    input  logic        img_partial,
    output logic        busy,
    output logic        done,
    output logic [2:0]  err_code,
    output logic        bus_req,
    output logic        bus_we,
    output logic [11:0] bus_addr,
    output logic [31:0] bus_wdata,
    input  logic        bus_ack,
    input  logic [31:0] bus_rdata
);

    localparam int POLL_CYC    = CLK_PER_US * POLL_US;
    localparam int READY_TRIES = (READY_TMO_US + POLL_US - 1) / POLL_US;
    localparam int USER_TRIES  = (USER_TMO_US + POLL_US - 1) / POLL_US;
    localparam int MAX_TRIES   = (READY_TRIES > USER_TRIES) ? READY_TRIES : USER_TRIES;
    localparam int TRY_W       = $clog2(MAX_TRIES + 1);
    localparam int WAIT_W      = $clog2(POLL_CYC + 1);
    localparam int BURST_W     = $clog2(DUMMY_WORDS + 1);

    seq_t cur, nx;

    logic [7:0]         ratio_sel;
    logic               brst_load, brst_dec;
    logic [BURST_W-1:0] brst_cnt;
    logic               brst_zero;
    logic               try_load, try_dec;
    logic [TRY_W-1:0]   try_val, try_cnt;
    logic               try_zero;
    logic               wait_load, wait_dec;
    logic [WAIT_W-1:0]  wait_cnt;
    logic               wait_zero;
    logic [31:0]        poll_mask, poll_val;
    logic               poll_hit;

    pr_seq_ratio u_ratio (
        .compressed (img_compressed),
        .encrypted  (img_encrypted),
        .ratio      (ratio_sel)
    );

    pr_seq_countdown #(.W(BURST_W)) u_burst_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (brst_load),
        .load_val (BURST_W'(DUMMY_WORDS)),
        .dec      (brst_dec),
        .count    (brst_cnt),
        .is_zero  (brst_zero)
    );

    pr_seq_countdown #(.W(TRY_W)) u_try_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (try_load),
        .load_val (try_val),
        .dec      (try_dec),
        .count    (try_cnt),
        .is_zero  (try_zero)
    );

    pr_seq_countdown #(.W(WAIT_W)) u_wait_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (wait_load),
        .load_val (WAIT_W'(POLL_CYC - 1)),
        .dec      (wait_dec),
        .count    (wait_cnt),
        .is_zero  (wait_zero)
    );

    // Poll target by kind
    always_comb begin
        unique case (cur.poll)
            POLL_RDY_SET: begin
                poll_mask = 32'(1) << ST_BIT_READY;
                poll_val  = 32'(1) << ST_BIT_READY;
            end
            POLL_RDY_CLR: begin
                poll_mask = 32'(1) << ST_BIT_READY;
                poll_val  = '0;
            end
            default: begin
                poll_mask = (32'(1) << ST_BIT_USER) | (32'(1) << ST_BIT_FABCLK);
                poll_val  = (32'(1) << ST_BIT_USER) | (32'(1) << ST_BIT_FABCLK);
            end
        endcase
        poll_hit = ((bus_rdata & poll_mask) == poll_val);
    end

    // Next-state logic
    always_comb begin
        nx        = cur;
        nx.done   = 1'b0;
        brst_load = 1'b0;
        brst_dec  = 1'b0;
        try_dec   = 1'b0;
        wait_load = 1'b0;
        wait_dec  = 1'b0;

        unique case (cur.state)
            ST_IDLE: begin
                if (setup_go || finish_go) begin
                    nx.err = ERR_NONE;
                    if (img_partial) begin
                        nx.err  = ERR_PARTIAL;
                        nx.done = 1'b1;
                    end else if (setup_go) begin
                        nx.state = ST_CHECK;
                        nx.ratio = ratio_sel;
                    end else begin
                        nx.state  = ST_TD_PROG_RD;
                        nx.td_ret = ST_FIN_ERR_RD;
                    end
                end
            end
            ST_CHECK: if (bus_ack) begin
                if (!bus_rdata[ST_BIT_ENABLE]) begin
                    nx.err   = ERR_NOT_ENABLED;
                    nx.done  = 1'b1;
                    nx.state = ST_IDLE;
                end else if (bus_rdata[ST_BIT_READY]) begin
                    nx.state  = ST_TD_PROG_RD;
                    nx.td_ret = ST_CLKSEL_RD;
                end else begin
                    nx.state = ST_CLKSEL_RD;
                end
            end
            ST_CLKSEL_RD: if (bus_ack) begin
                nx.data  = bus_rdata;
                nx.state = ST_CLKSEL_WR;
            end
            ST_CLKSEL_WR: if (bus_ack) nx.state = ST_MODE_RD;
            ST_MODE_RD: if (bus_ack) begin
                nx.data  = bus_rdata;
                nx.state = ST_MODE_WR;
            end
            ST_MODE_WR: if (bus_ack) begin
                nx.state = ST_BURST_RD;
                nx.ret   = ST_REQ_RD;
            end
            ST_REQ_RD: if (bus_ack) begin
                nx.data  = bus_rdata;
                nx.state = ST_REQ_WR;
            end
            ST_REQ_WR: if (bus_ack) begin
                nx.state = ST_POLL_RD;
                nx.poll  = POLL_RDY_SET;
            end
            ST_XFER_RD: if (bus_ack) begin
                nx.data  = bus_rdata;
                nx.state = ST_XFER_WR;
            end
            ST_XFER_WR: if (bus_ack) nx.state = ST_RATIO_RD;
            ST_RATIO_RD: if (bus_ack) begin
                nx.data  = bus_rdata;
                nx.state = ST_RATIO_WR;
            end
            ST_RATIO_WR: if (bus_ack) begin
                nx.state = ST_IDLE;
                nx.done  = 1'b1;
            end
            ST_TD_PROG_RD: if (bus_ack) begin
                nx.data  = bus_rdata;
                nx.state = ST_TD_XFER_CLR;
            end
            ST_TD_XFER_CLR: if (bus_ack) nx.state = ST_TD_CFG_CLR;
            ST_TD_CFG_CLR: if (bus_ack) begin
                nx.state = ST_BURST_RD;
                nx.ret   = ST_POLL_RD;
                nx.poll  = POLL_RDY_CLR;
            end
            ST_FIN_ERR_RD: if (bus_ack) begin
                if (bus_rdata[UNCOR_BIT_CFG]) begin
                    nx.err   = ERR_LATCHED;
                    nx.done  = 1'b1;
                    nx.state = ST_IDLE;
                end else begin
                    nx.state = ST_FIN_MODE_RD;
                end
            end
            ST_FIN_MODE_RD: if (bus_ack) begin
                nx.data  = bus_rdata;
                nx.state = ST_FIN_MODE_WR;
            end
            ST_FIN_MODE_WR: if (bus_ack) begin
                nx.state = ST_POLL_RD;
                nx.poll  = POLL_USER;
            end
            ST_BURST_RD: if (bus_ack) begin
                nx.data  = bus_rdata;
                nx.state = ST_BURST_WR;
            end
            ST_BURST_WR: if (bus_ack) begin
                brst_load = 1'b1;
                nx.state  = ST_BURST_DATA;
            end
            ST_BURST_DATA: if (bus_ack) begin
                if (brst_cnt <= BURST_W'(1)) begin
                    nx.state = cur.ret;
                end else begin
                    brst_dec = 1'b1;
                end
            end
            ST_POLL_RD: if (bus_ack) begin
                if (poll_hit) begin
                    unique case (cur.poll)
                        POLL_RDY_SET: begin
                            nx.state = ST_BURST_RD;
                            nx.ret   = ST_XFER_RD;
                        end
                        POLL_RDY_CLR: nx.state = cur.td_ret;
                        default: begin
                            nx.state = ST_IDLE;
                            nx.done  = 1'b1;
                        end
                    endcase
                end else if (try_cnt <= TRY_W'(1)) begin
                    nx.err   = (cur.poll == POLL_USER) ? ERR_USER_TIMEOUT : ERR_READY_TIMEOUT;
                    nx.done  = 1'b1;
                    nx.state = ST_IDLE;
                end else begin
                    try_dec   = 1'b1;
                    wait_load = 1'b1;
                    nx.state  = ST_POLL_WAIT;
                end
            end
            ST_POLL_WAIT: begin
                if (wait_zero) begin
                    nx.state = ST_POLL_RD;
                end else begin
                    wait_dec = 1'b1;
                end
            end
            default: nx.state = ST_IDLE;
        endcase

        try_load = (nx.state == ST_POLL_RD) && (cur.state != ST_POLL_RD)
                   && (cur.state != ST_POLL_WAIT);
        try_val  = (nx.poll == POLL_USER) ? TRY_W'(USER_TRIES) : TRY_W'(READY_TRIES);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur <= '{state: ST_IDLE, ret: ST_IDLE, td_ret: ST_IDLE, poll: POLL_RDY_SET,
                     data: '0, ratio: '0, err: ERR_NONE, done: 1'b0};
        end else begin
            cur <= nx;
        end
    end

    // Bus drive decoded from the current step
    always_comb begin
        bus_req   = 1'b1;
        bus_we    = 1'b0;
        bus_addr  = ADDR_STATUS;
        bus_wdata = '0;
        unique case (cur.state)
            ST_IDLE, ST_POLL_WAIT: bus_req = 1'b0;
            ST_CHECK, ST_POLL_RD:  bus_addr = ADDR_STATUS;
            ST_CLKSEL_RD, ST_MODE_RD, ST_RATIO_RD, ST_FIN_MODE_RD, ST_BURST_RD:
                bus_addr = ADDR_MODE;
            ST_REQ_RD, ST_XFER_RD, ST_TD_PROG_RD:
                bus_addr = ADDR_PROG;
            ST_FIN_ERR_RD: bus_addr = ADDR_UNCOR;
            ST_CLKSEL_WR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_MODE;
                bus_wdata = cur.data | MODE_CLKSEL;
            end
            ST_MODE_WR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_MODE;
                bus_wdata = cur.data | MODE_CFG;
            end
            ST_RATIO_WR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_MODE;
                bus_wdata = (cur.data & ~MODE_CNT_MASK) | {16'h0, cur.ratio, 8'h0};
            end
            ST_FIN_MODE_WR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_MODE;
                bus_wdata = cur.data & ~(MODE_CFG | MODE_CLKSEL);
            end
            ST_BURST_WR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_MODE;
                bus_wdata = (cur.data & ~MODE_CNT_MASK) | 32'h0000_0100;
            end
            ST_REQ_WR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_PROG;
                bus_wdata = cur.data | PROG_REQ;
            end
            ST_XFER_WR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_PROG;
                bus_wdata = cur.data | PROG_XFER;
            end
            ST_TD_XFER_CLR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_PROG;
                bus_wdata = cur.data & ~PROG_XFER;
            end
            ST_TD_CFG_CLR: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_PROG;
                bus_wdata = cur.data & ~(PROG_XFER | PROG_REQ);
            end
            ST_BURST_DATA: begin
                bus_we    = 1'b1;
                bus_addr  = ADDR_DATA;
                bus_wdata = '0;
            end
            default: bus_req = 1'b0;
        endcase
    end

    assign busy     = (cur.state != ST_IDLE);
    assign done     = cur.done;
    assign err_code = cur.err;

endmodule

// File: rtl/pr_seq_chk.sv
module pr_seq_chk
    import pr_seq_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        setup_go,
    input logic        img_partial,
    input logic        busy,
    input logic        done,
    input logic [2:0]  err_code,
    input logic        bus_req,
    input logic        bus_we,
    input logic [11:0] bus_addr,
    input logic [31:0] bus_wdata,
    input logic        bus_ack
);

    logic [7:0] last_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_cnt_q <= '0;
        end else if (bus_req && bus_we && bus_ack && bus_addr == ADDR_MODE) begin
            last_cnt_q <= bus_wdata[15:8];
        end
    end

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata))); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_req); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

    AST_PARTIAL_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && setup_go && img_partial) |=> (done && !busy && err_code == 3'd5)); // R1

    AST_DUMMY_AT_UNIT_RATIO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_DATA) |-> (last_cnt_q == 8'd1)); // R4

    AST_DUMMY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_we && bus_addr == ADDR_DATA) |-> (bus_wdata == '0)); // R4

endmodule

bind pr_setup_seq pr_seq_chk u_pr_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_go    (setup_go),
    .img_partial (img_partial),
    .busy        (busy),
    .done        (done),
    .err_code    (err_code),
    .bus_req     (bus_req),
    .bus_we      (bus_we),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_ack     (bus_ack)
);

// File: tb/test_pr_setup_seq.sv
module test_pr_setup_seq;

    localparam logic [11:0] A_STATUS = 12'h21C;
    localparam logic [11:0] A_MODE   = 12'h220;
    localparam logic [11:0] A_DATA   = 12'h228;
    localparam logic [11:0] A_PROG   = 12'h22C;
    localparam logic [11:0] A_UNCOR  = 12'h234;
    localparam int N_DUMMY = 244;
    localparam int N_USER  = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic setup_go = 1'b0, finish_go = 1'b0;
    logic img_compressed = 1'b0, img_encrypted = 1'b0, img_partial = 1'b0;
    logic busy, done;
    logic [2:0] err_code;
    logic bus_req, bus_we;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata;
    logic bus_ack = 1'b0;
    logic [31:0] bus_rdata = '0;

    always #5 clk = ~clk;

    pr_setup_seq #(.CLK_PER_US(2)) i_pr_setup_seq (
        .clk(clk), .rst_n(rst_n), .setup_go(setup_go), .finish_go(finish_go),
        .img_compressed(img_compressed), .img_encrypted(img_encrypted),
        .img_partial(img_partial), .busy(busy), .done(done), .err_code(err_code),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata)
    );

    typedef struct {
        logic        we;
        logic [11:0] addr;
        logic [31:0] data;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int n_checks = 0;
    int n_fails  = 0;

    // device model
    logic [31:0] m_mode, m_prog, m_uncor;
    int          m_rdy_mode;   // 0 follows request bit, 1 stuck 0, 2 stuck 1
    logic        m_en, m_usr;
    // expected copies kept by the driver
    logic [31:0] e_mode, e_prog;

    function automatic logic [31:0] status_word();
        logic rdy;
        rdy = (m_rdy_mode == 0) ? m_prog[0] : (m_rdy_mode == 2);
        return (32'(m_en) << 20) | (32'(rdy) << 18) |
               (m_usr ? ((32'(1) << 21) | (32'(1) << 24)) : 32'h0);
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, expv);
        end
    endtask

    // Monitor / slave: pops expected transactions and compares
    initial begin
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12", "unexpected transaction addr", {20'h0, bus_addr}, 32'h0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(bus_we == e.we && bus_addr == e.addr, e.tag, "transaction kind/addr",
                          {19'h0, bus_we, bus_addr}, {19'h0, e.we, e.addr});
                    if (bus_we && e.we && bus_addr == e.addr)
                        check(bus_wdata == e.data, e.tag, "write data", bus_wdata, e.data);
                end
                if (bus_we) begin
                    if (bus_addr == A_MODE) m_mode = bus_wdata;
                    if (bus_addr == A_PROG) m_prog = bus_wdata;
                end else begin
                    case (bus_addr)
                        A_STATUS: bus_rdata = status_word();
                        A_MODE:   bus_rdata = m_mode;
                        A_PROG:   bus_rdata = m_prog;
                        A_UNCOR:  bus_rdata = m_uncor;
                        default:  bus_rdata = 32'hDEAD_BEEF;
                    endcase
                end
                bus_ack = 1'b1;
            end
        end
    end

    task automatic push(input bit we, input logic [11:0] a, input logic [31:0] d, input string tag);
        exp_t e;
        e.we = we; e.addr = a; e.data = d; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic preset(input logic [31:0] mode, input logic [31:0] prog, input int rdy_mode,
                          input bit en, input bit usr, input logic [31:0] uncor);
        m_mode = mode; m_prog = prog; m_rdy_mode = rdy_mode;
        m_en = en; m_usr = usr; m_uncor = uncor;
        e_mode = mode; e_prog = prog;
    endtask

    task automatic exp_burst(input string tag);
        push(0, A_MODE, 0, tag);
        e_mode = (e_mode & ~32'h0000_FF00) | 32'h0000_0100;
        push(1, A_MODE, e_mode, tag);
        for (int i = 0; i < N_DUMMY; i++) push(1, A_DATA, 32'h0, "R4");
    endtask

    task automatic exp_teardown();
        push(0, A_PROG, 0, "R8");
        e_prog = e_prog & ~32'h2;
        push(1, A_PROG, e_prog, "R8");
        e_prog = e_prog & ~32'h3;
        push(1, A_PROG, e_prog, "R8");
        exp_burst("R8");
        push(0, A_STATUS, 0, "R8");
    endtask

    task automatic exp_setup(input bit td, input bit rdy_ok, input int ratio);
        push(0, A_STATUS, 0, "R2");
        if (td) exp_teardown();
        push(0, A_MODE, 0, "R3");
        e_mode = e_mode | 32'h2;
        push(1, A_MODE, e_mode, "R3");
        push(0, A_MODE, 0, "R3");
        e_mode = e_mode | 32'h1;
        push(1, A_MODE, e_mode, "R3");
        exp_burst("R4");
        push(0, A_PROG, 0, "R5");
        e_prog = e_prog | 32'h1;
        push(1, A_PROG, e_prog, "R5");
        push(0, A_STATUS, 0, "R5");
        if (!rdy_ok) return;
        exp_burst("R6");
        push(0, A_PROG, 0, "R6");
        e_prog = e_prog | 32'h2;
        push(1, A_PROG, e_prog, "R6");
        push(0, A_MODE, 0, "R6");
        e_mode = (e_mode & ~32'h0000_FF00) | (32'(ratio) << 8);
        push(1, A_MODE, e_mode, "R6");
    endtask

    task automatic exp_finish(input bit latched, input int n_status);
        exp_teardown();
        push(0, A_UNCOR, 0, "R9");
        if (latched) return;
        push(0, A_MODE, 0, "R9");
        e_mode = e_mode & ~32'h3;
        push(1, A_MODE, e_mode, "R9");
        for (int i = 0; i < n_status; i++) push(0, A_STATUS, 0, "R9");
    endtask

    task automatic issue(input bit is_setup, input bit comp, input bit enc, input bit part);
        @(negedge clk);
        img_compressed = comp; img_encrypted = enc; img_partial = part;
        setup_go = is_setup; finish_go = !is_setup;
        @(negedge clk);
        setup_go = 1'b0; finish_go = 1'b0;
        if (!part) check(busy == 1'b1, "R10", "busy after accept", {31'h0, busy}, 32'h1);
    endtask

    task automatic wait_done(input logic [2:0] exp_err, input string tag);
        while (!done) @(negedge clk);
        check(err_code == exp_err, tag, "err_code", {29'h0, err_code}, {29'h0, exp_err});
        check(exp_q.size() == 0, tag, "missing transactions", exp_q.size(), 0);
        check(busy == 1'b0, "R10", "busy at done", {31'h0, busy}, 32'h0);
        @(negedge clk);
        check(done == 1'b0, "R10", "done width", {31'h0, done}, 32'h0);
        check(err_code == exp_err, "R10", "err_code held", {29'h0, err_code}, {29'h0, exp_err});
        exp_q.delete();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not complete, actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        preset(32'hABCD_3C80, 32'h0, 0, 1'b1, 1'b1, 32'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check(busy == 1'b0 && done == 1'b0 && bus_req == 1'b0, "R10", "reset outputs",
              {29'h0, busy, done, bus_req}, 32'h0);
        check(err_code == 3'd0, "R10", "reset err_code", {29'h0, err_code}, 32'h0);

        // R1 partial rejected, both commands
        issue(1, 0, 0, 1);
        check(done == 1'b1 && busy == 1'b0, "R1", "immediate done", {30'h0, done, busy}, 32'h2);
        wait_done(3'd5, "R1");
        issue(0, 0, 0, 1);
        wait_done(3'd5, "R1");

        // R2 enable clear
        preset(32'hABCD_3C80, 32'h0, 0, 1'b0, 1'b1, 32'h0);
        push(0, A_STATUS, 0, "R2");
        issue(1, 0, 0, 0);
        wait_done(3'd1, "R2");

        // R3 R4 R5 R6 plain setup, ratio 1
        preset(32'hABCD_3C80, 32'h0, 0, 1'b1, 1'b1, 32'h0);
        exp_setup(0, 1, 1);
        issue(1, 0, 0, 0);
        wait_done(3'd0, "R6");

        // R8 R9 finish success
        exp_finish(0, 1);
        issue(0, 0, 0, 0);
        wait_done(3'd0, "R9");

        // R7 ready already set, R6 compressed+encrypted gives 8, R11 commands ignored
        preset(32'h1234_0000, 32'h3, 0, 1'b1, 1'b1, 32'h0);
        exp_setup(1, 1, 8);
        issue(1, 1, 1, 0);
        repeat (40) @(negedge clk);
        setup_go = 1'b1; finish_go = 1'b1;
        @(negedge clk);
        setup_go = 1'b0; finish_go = 1'b0;
        wait_done(3'd0, "R11");

        // R6 encrypted only gives 4
        preset(32'h0000_0000, 32'h0, 0, 1'b1, 1'b1, 32'h0);
        exp_setup(0, 1, 4);
        issue(1, 0, 1, 0);
        wait_done(3'd0, "R6");

        // R5 ready never rises
        preset(32'h0000_0000, 32'h0, 1, 1'b1, 1'b1, 32'h0);
        exp_setup(0, 0, 1);
        issue(1, 0, 0, 0);
        wait_done(3'd2, "R5");

        // R8 teardown ready stuck high
        preset(32'h0000_0300, 32'h3, 2, 1'b1, 1'b1, 32'h0);
        exp_teardown();
        issue(0, 0, 0, 0);
        wait_done(3'd2, "R8");

        // R9 latched configuration error
        preset(32'h0000_0103, 32'h3, 0, 1'b1, 1'b1, 32'h0000_0020);
        exp_finish(1, 0);
        issue(0, 0, 0, 0);
        wait_done(3'd3, "R9");

        // R9 user mode never reached: 200 reads
        preset(32'h0000_0103, 32'h3, 0, 1'b1, 1'b0, 32'h0);
        exp_finish(0, N_USER);
        issue(0, 0, 0, 0);
        wait_done(3'd4, "R9");

        repeat (5) @(negedge clk);
        summary();
        $finish;
    end

endmodule